// File: doc/BRIEF.md
# Program Counter and Link Unit

This block holds the architectural program counter together with a staged next-instruction address. While an instruction executes, the staged value defaults to the sequential successor (current PC plus a fixed step). The instruction may instead replace it with an absolute 64-bit target, or with a target computed as the current PC plus a signed offset. A commit pulse retires the instruction: the resolved next address becomes the PC, and the staged register is reloaded with the new PC plus the step.

A link request drives a write port toward the register file. The port carries a fixed destination index and the staged next address as it stood before any branch in the same cycle replaced it, so a call saves its return address. On every commit the block also pulses a strobe that tells the register file to clear the entry it hands out as the constant-zero source.

The reset input is asynchronous and active low, and the block releases it on the clock. On reset the PC loads a reset-vector parameter and the staged address loads that vector plus the step.

Top module: `pcl_unit`

## Requirements
- R1: While reset is active, and after it is released, until the first request: `pc_o` equals RESET_VEC and `npc_o` equals RESET_VEC+STEP (modulo 2^AW). The reset release reaches the registers on the second rising edge after `rst_n` rises.
- R2: In a cycle with no branch and no commit, `pc_o` and `npc_o` keep their values across the next edge.
- R3: With `br_abs_i`=1 and `commit_i`=0, `npc_o` equals `target_i` after the edge and `pc_o` is unchanged.
- R4: With `br_rel_i`=1, `br_abs_i`=0 and `commit_i`=0, `npc_o` equals `pc_o` plus the two's-complement `offset_i` (modulo 2^AW) after the edge. The current PC is the base, not the staged value.
- R5: When `br_abs_i` and `br_rel_i` are both 1, the absolute target wins.
- R6: With `commit_i`=1, the resolved next address goes into `pc_o` after the edge: the branch target if a branch is requested in that cycle, otherwise the staged `npc_o`. In the same edge `npc_o` becomes that address plus STEP.
- R7: `link_we_o` follows `link_i` in the same cycle. While `link_we_o` is 1, `link_idx_o` is LINK_IDX (30 by default) and `link_data_o` equals the `npc_o` present in that cycle, even when a branch is requested in the same cycle.
- R8: `zr_clr_o` is 1 in exactly the cycles in which `commit_i` is 1 and reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| br_abs_i | input | 1 | Request to load an absolute target |
| br_rel_i | input | 1 | Request to load the PC-relative target |
| target_i | input | AW | Absolute target address |
| offset_i | input | AW | Signed offset added to the current PC |
| link_i | input | 1 | Request to write the return address |
| commit_i | input | 1 | Retire the current instruction |
| pc_o | output | AW | Current program counter |
| npc_o | output | AW | Staged next address |
| link_we_o | output | 1 | Register-file write enable for the link |
| link_idx_o | output | IDX_W | Register index of the link write |
| link_data_o | output | AW | Return address to write |
| zr_clr_o | output | 1 | Strobe that clears the zero-source register |

## Verification
The bench builds the block with AW=16, STEP=4 and RESET_VEC=0x0100. At a 16-bit width the address wraps within reach, so sweeps of negative and positive offsets, and absolute targets near both ends of the address space, exercise the modular arithmetic that a 64-bit build would hide. A reference model of two 16-bit variables predicts every value. The sweeps cover every combination of the branch, link and commit inputs, which includes a link and a branch in the same cycle, and a commit with and without a redirect.

// File: rtl/pcl_pkg.sv
package pcl_pkg;
  typedef enum logic [1:0] {
    TSEL_SEQ = 2'd0,
    TSEL_ABS = 2'd1,
    TSEL_REL = 2'd2
  } tsel_e;
endpackage

// File: rtl/pcl_incr.sv
module pcl_incr #(
  parameter int AW   = 64,
  parameter int STEP = 4
) (
  input  logic [AW-1:0] base_i,
  output logic [AW-1:0] sum_o
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  always_comb begin
    sum_o = base_i + STEP_V;
  end
endmodule

// File: rtl/pcl_target_sel.sv
module pcl_target_sel
  import pcl_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic          abs_req_i,
  input  logic          rel_req_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] npc_i,
  input  logic [AW-1:0] target_i,
  input  logic [AW-1:0] offset_i,
  output tsel_e         sel_o,
  output logic [AW-1:0] eff_o
);
  logic [AW-1:0] rel_sum;

  always_comb begin
    rel_sum = pc_i + offset_i;
  end

  always_comb begin
    if (abs_req_i)      sel_o = TSEL_ABS;
    else if (rel_req_i) sel_o = TSEL_REL;
    else                sel_o = TSEL_SEQ;
  end

  always_comb begin
    unique case (sel_o)
      TSEL_ABS: eff_o = target_i;
      TSEL_REL: eff_o = rel_sum;
      default:  eff_o = npc_i;
    endcase
  end
endmodule

// File: rtl/pcl_link_port.sv
module pcl_link_port #(
  parameter int AW       = 64,
  parameter int IDX_W    = 5,
  parameter int LINK_IDX = 30
) (
  input  logic             link_req_i,
  input  logic [AW-1:0]    staged_i,
  output logic             we_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [AW-1:0]    data_o
);
  localparam logic [IDX_W-1:0] IDX_V = IDX_W'(LINK_IDX);

  always_comb begin
    we_o   = link_req_i;
    idx_o  = IDX_V;
    data_o = staged_i;
  end
endmodule

// File: rtl/pcl_unit.sv
module pcl_unit
  import pcl_pkg::*;
#(
  parameter int              AW        = 64,
  parameter int              STEP      = 4,
  parameter int              IDX_W     = 5,
  parameter int              LINK_IDX  = 30,
  parameter logic [63:0]     RESET_VEC = 64'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_abs_i,
  input  logic             br_rel_i,
  input  logic [AW-1:0]    target_i,
  input  logic [AW-1:0]    offset_i,
  input  logic             link_i,
  input  logic             commit_i,
  output logic [AW-1:0]    pc_o,
  output logic [AW-1:0]    npc_o,
  output logic             link_we_o,
  output logic [IDX_W-1:0] link_idx_o,
  output logic [AW-1:0]    link_data_o,
  output logic             zr_clr_o
);
  localparam logic [AW-1:0] RST_PC  = RESET_VEC[AW-1:0];
  localparam logic [AW-1:0] RST_NPC = RST_PC + AW'(STEP);

  // reset release synchronizer
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [AW-1:0] pc_q, npc_q;
  logic [AW-1:0] pc_d, npc_d;
  logic          pc_en, npc_en;
  logic [AW-1:0] eff_next, eff_plus;
  tsel_e         tsel;

  pcl_target_sel #(.AW(AW)) u_sel (
    .abs_req_i (br_abs_i),
    .rel_req_i (br_rel_i),
    .pc_i      (pc_q),
    .npc_i     (npc_q),
    .target_i  (target_i),
    .offset_i  (offset_i),
    .sel_o     (tsel),
    .eff_o     (eff_next)
  );

  pcl_incr #(.AW(AW), .STEP(STEP)) u_incr (
    .base_i (eff_next),
    .sum_o  (eff_plus)
  );

  pcl_link_port #(.AW(AW), .IDX_W(IDX_W), .LINK_IDX(LINK_IDX)) u_link (
    .link_req_i (link_i),
    .staged_i   (npc_q),
    .we_o       (link_we_o),
    .idx_o      (link_idx_o),
    .data_o     (link_data_o)
  );

  // next-state
  always_comb begin
    pc_en  = commit_i;
    npc_en = commit_i || (tsel != TSEL_SEQ);
    pc_d   = eff_next;
    npc_d  = commit_i ? eff_plus : eff_next;
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pc_q <= RST_PC;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      npc_q <= RST_NPC;
    end else if (npc_en) begin
      npc_q <= npc_d;
    end
  end

  assign pc_o     = pc_q;
  assign npc_o    = npc_q;
  assign zr_clr_o = commit_i && rst_int_n;

  // assertions
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!commit_i && !br_abs_i && !br_rel_i) |=> ($stable(pc_o) && $stable(npc_o))); // R2
  AST_ABS_LOAD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (br_abs_i && !commit_i) |=> (npc_o == $past(target_i) && $stable(pc_o))); // R3
  AST_REL_BASE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (br_rel_i && !br_abs_i && !commit_i) |=> (npc_o == $past(pc_o) + $past(offset_i))); // R4
  AST_SEQ_COMMIT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (commit_i && !br_abs_i && !br_rel_i) |=> (pc_o == $past(npc_o))); // R6
  AST_RESTAGE: assert property (@(posedge clk) disable iff (!rst_int_n)
    commit_i |=> (npc_o == pc_o + AW'(STEP))); // R6
  AST_LINK_VALUE: assert property (@(posedge clk) disable iff (!rst_int_n)
    link_we_o |-> (link_data_o == npc_o && link_idx_o == IDX_W'(LINK_IDX))); // R7
  AST_ZR_STROBE: assert property (@(posedge clk) disable iff (!rst_int_n)
    zr_clr_o == commit_i); // R8
endmodule

// File: tb/sim_pcl_unit.sv
module sim_pcl_unit;
  localparam int AW = 16;
  localparam int STEP = 4;
  localparam logic [AW-1:0] RV = 16'h0100;

  logic clk = 1'b0;
  logic rst_n;
  logic br_abs, br_rel, link, commit;
  logic [AW-1:0] tgt, off;
  logic [AW-1:0] pc, npc, ldata;
  logic lwe, zr;
  logic [4:0] lidx;

  int n_tests = 0;
  int n_fail = 0;
  logic [AW-1:0] mpc, mnpc;

  always #5 clk = ~clk;

  pcl_unit #(.AW(AW), .STEP(STEP), .IDX_W(5), .LINK_IDX(30),
             .RESET_VEC(64'h0100)) u0 (
    .clk(clk), .rst_n(rst_n), .br_abs_i(br_abs), .br_rel_i(br_rel),
    .target_i(tgt), .offset_i(off), .link_i(link), .commit_i(commit),
    .pc_o(pc), .npc_o(npc), .link_we_o(lwe), .link_idx_o(lidx),
    .link_data_o(ldata), .zr_clr_o(zr)
  );

  task automatic chk(input string tag, input string what,
                     input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic go(input bit a, input bit r, input bit l, input bit c,
                    input logic [AW-1:0] t, input logic [AW-1:0] o);
    string tag;
    logic [AW-1:0] eff;
    @(negedge clk);
    br_abs = a; br_rel = r; link = l; commit = c; tgt = t; off = o;
    #1;
    chk("R7", "link_we", AW'(lwe), AW'(l));
    if (l) begin
      chk("R7", "link_data", ldata, mnpc);
      chk("R7", "link_idx", AW'(lidx), 16'd30);
    end
    chk("R8", "zr_clr", AW'(zr), AW'(c));
    eff = a ? t : (r ? mpc + o : mnpc);
    if (c) begin
      mpc = eff; mnpc = eff + 16'(STEP); tag = "R6";
    end else begin
      mnpc = eff;
      tag = a ? (r ? "R5" : "R3") : (r ? "R4" : "R2");
    end
    @(posedge clk); #1;
    br_abs = 0; br_rel = 0; link = 0; commit = 0;
    chk(tag, "pc", pc, mpc);
    chk(tag, "npc", npc, mnpc);
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    chk("R1", "pc in reset", pc, RV);
    chk("R1", "npc in reset", npc, RV + 16'(STEP));
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1", "pc after release", pc, RV);
    chk("R1", "npc after release", npc, RV + 16'(STEP));
    mpc = RV; mnpc = RV + 16'(STEP);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    br_abs = 0; br_rel = 0; link = 0; commit = 0; tgt = '0; off = '0;
    do_reset();
    // R2 idle hold, then sequential commits
    go(0, 0, 0, 0, 16'h0, 16'h0);
    for (int i = 0; i < 4; i++) go(0, 0, 0, 1, 16'h0, 16'h0);
    // exhaustive control sweep with varied data
    for (int m = 0; m < 16; m++) begin
      for (int k = 0; k < 6; k++) begin
        go(m[0], m[1], m[2], m[3], 16'(16'hFFF0 + k * 16'h1357),
           16'(k * 16'h2A3 - 16'h700));
      end
    end
    // R4 offset sweep around zero and wrap
    for (int o = -64; o <= 64; o += 4) go(0, 1, 0, 0, 16'h0, 16'(o));
    for (int o = -64; o <= 64; o += 8) go(0, 1, 1, 1, 16'h0, 16'(o));
    // R3 / R6 absolute targets at the ends of the space
    go(1, 0, 0, 1, 16'hFFFC, 16'h0);
    go(0, 0, 0, 1, 16'h0, 16'h0);
    go(1, 0, 1, 0, 16'h0000, 16'h0);
    go(0, 1, 0, 1, 16'h0, 16'hFFF8);
    // R7 link together with branch: captures staged sequential value
    go(1, 0, 1, 0, 16'h4000, 16'h0);
    go(0, 0, 1, 0, 16'h0, 16'h0);
    // mid-run reset
    do_reset();
    go(0, 0, 0, 1, 16'h0, 16'h0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule